// File: doc/BRIEF.md
# Idle Channel Quiet Pattern Switchover

This block sits on the transmit bit path of a delta-modulation voice encoder and runs on the encoder bit clock. On each bit clock it passes either the encoder output bit or a quiet pattern to the next stage. The quiet pattern is an alternating one/zero sequence, which is the lowest-amplitude signal the link can carry. The quiet pattern is chosen automatically when an external averaging comparator reports that the audio level has stayed below its threshold for a programmable number of 32-clock blocks. Software can also force the quiet pattern at any time.

The level comparison happens outside the block and arrives as one flag. The block owns the run-length timer and the registered idle-detected status flag. It also owns the pattern generator and the output source selection. Leaving the quiet pattern is immediate. A disable bit stops automatic switching but leaves the status flag working. A power-down bit stops idle detection altogether.

Top module: `idle_quiet_switch`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_bit` and `idle_flag` are 0 after that edge.
- R2: While the quiet pattern is selected, `tx_bit` is 1 after the first selected edge and inverts after every further selected edge.
- R3: With `dly_code` = N, `idle_flag` rises after the (32*N+1)-th consecutive edge at which `below_thr` is sampled 1. N = 0 raises it after the first such edge, and N = 15 after the 481st.
- R4: An edge at which `below_thr` is 0 clears `idle_flag`. Unless `force_quiet` is set, that same edge also returns `tx_bit` to the encoder bit.
- R5: If `below_thr` drops to 0 before the delay expires, the run count restarts from zero. A later run then needs the full 32*N+1 edges again.
- R6: With `auto_off` = 1, `idle_flag` still rises and falls per R3 and R4, but `tx_bit` carries the encoder bit unless `force_quiet` is set.
- R7: With `force_quiet` = 1 at an edge, `tx_bit` carries the quiet pattern after that edge. This holds whatever the values of `below_thr`, `dly_code`, `auto_off` and `pwr_down`.
- R8: With `pwr_down` = 1 at an edge, `idle_flag` is 0 and the run count is cleared after that edge. No automatic selection occurs while it is set.
- R9: When the quiet pattern is not selected, `tx_bit` after an edge equals `enc_bit` sampled at that edge.
- R10: With `auto_off` = 0 and `force_quiet` = 0, automatic selection of the quiet pattern takes effect on the same edge at which `idle_flag` rises, and ends on the same edge at which it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder bit clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_bit | input | 1 | Encoder output bit |
| below_thr | input | 1 | 1 when the averaged level is below threshold |
| dly_code | input | 4 | Delay in 32-clock blocks before automatic selection |
| auto_off | input | 1 | 1 blocks automatic selection only |
| force_quiet | input | 1 | 1 selects the quiet pattern unconditionally |
| pwr_down | input | 1 | 1 halts idle detection |
| tx_bit | output | 1 | Selected transmit bit (registered) |
| idle_flag | output | 1 | Registered idle-detected status |

## Verification
On every cycle, the assertions check several rules. Power-down clears the status and the timer. A low level flag drops the status on the next edge. The pattern starts at 1 and then alternates. A forced selection drives the pattern. With automatic switching disabled, the encoder bit passes through. Automatic selection tracks the status flag. Only the bench scenarios can show the exact edge on which the status rises for a given delay code. They also show the restart of the count after an interrupted run, the full wait at the largest code, and the need for a fresh full run after power-down.

// File: rtl/idle_sw_pkg.sv
package idle_sw_pkg;

    localparam int CODE_W_DEF      = 4;
    localparam int BLOCK_SHIFT_DEF = 5;

    typedef enum logic {
        SRC_ENC   = 1'b0,
        SRC_QUIET = 1'b1
    } src_e;

    // Selection request presented to the output stage for one edge
    typedef struct packed {
        logic quiet;
        logic pat_bit;
        logic enc_bit;
    } sel_req_t;

    function automatic src_e pick_src(input logic force_q, input logic auto_blk,
                                      input logic idle_n);
        return (force_q || (idle_n && !auto_blk)) ? SRC_QUIET : SRC_ENC;
    endfunction

endpackage

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int CODE_W      = idle_sw_pkg::CODE_W_DEF,
    parameter int BLOCK_SHIFT = idle_sw_pkg::BLOCK_SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              below,
    input  logic              pdn,
    input  logic [CODE_W-1:0] code,
    output logic              idle_next,
    output logic              idle_q
);
    localparam int CNT_W = CODE_W + BLOCK_SHIFT;
    localparam logic [CNT_W-1:0] CNT_MAX = {{CODE_W{1'b1}}, {BLOCK_SHIFT{1'b0}}};

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] limit;

    assign limit = {code, {BLOCK_SHIFT{1'b0}}};

    always_comb begin
        run_d     = run_q;
        idle_next = 1'b0;
        if (pdn || !below) begin
            run_d = '0;
        end else begin
            idle_next = (run_q >= limit);
            if (run_q < CNT_MAX) run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            idle_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            idle_q <= idle_next;
        end
    end

    // R8: power-down leaves the status low and the timer empty
    p_pdn_clear_r8: assert property (@(posedge clk) disable iff (rst)
        pdn |=> (!idle_q && run_q == '0));

    // R4: a level above threshold drops the status on the next edge
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        !below |=> !idle_q);

    // R3: the status can only rise after a below-threshold sample
    p_rise_after_run_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_q) |-> $past(below));

    // R5: a run shorter than the limit never raises the status
    p_short_run_r5: assert property (@(posedge clk) disable iff (rst)
        (below && !pdn && run_q < limit && !idle_q) |=> !idle_q);

endmodule

// File: rtl/quiet_pattern.sv
module quiet_pattern (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    output logic pat_next,
    output logic pat_q,
    output logic sel_q
);
    assign pat_next = sel_q ? ~pat_q : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_n;
            if (sel_n) pat_q <= pat_next;
        end
    end

    // R2: a fresh selection starts with a one
    p_first_one_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !sel_q) |=> pat_q);

    // R2: a held selection alternates every clock
    p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_n && sel_q) |=> (pat_q != $past(pat_q)));

endmodule

// File: rtl/idle_quiet_switch.sv
module idle_quiet_switch #(
    parameter int CODE_W      = idle_sw_pkg::CODE_W_DEF,
    parameter int BLOCK_SHIFT = idle_sw_pkg::BLOCK_SHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_bit,
    input  logic              below_thr,
    input  logic [CODE_W-1:0] dly_code,
    input  logic              auto_off,
    input  logic              force_quiet,
    input  logic              pwr_down,
    output logic              tx_bit,
    output logic              idle_flag
);
    import idle_sw_pkg::*;

    logic     idle_next;
    logic     pat_next;
    logic     pat_q;
    logic     sel_q;
    src_e     src_n;
    src_e     src_q;
    sel_req_t req;

    idle_timer #(.CODE_W(CODE_W), .BLOCK_SHIFT(BLOCK_SHIFT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .below     (below_thr),
        .pdn       (pwr_down),
        .code      (dly_code),
        .idle_next (idle_next),
        .idle_q    (idle_flag)
    );

    assign src_n = pick_src(force_quiet, auto_off, idle_next);

    quiet_pattern u_pat (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (src_n == SRC_QUIET),
        .pat_next (pat_next),
        .pat_q    (pat_q),
        .sel_q    (sel_q)
    );

    always_comb begin
        req.quiet   = (src_n == SRC_QUIET);
        req.pat_bit = pat_next;
        req.enc_bit = enc_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit <= 1'b0;
            src_q  <= SRC_ENC;
        end else begin
            tx_bit <= req.quiet ? req.pat_bit : req.enc_bit;
            src_q  <= src_n;
        end
    end

    // R7: forcing drives the quiet pattern to the output
    p_force_r7: assert property (@(posedge clk) disable iff (rst)
        force_quiet |=> (sel_q && tx_bit == pat_q));

    // R6: with automatic switching blocked, the encoder bit passes
    p_auto_off_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_off && !force_quiet) |=> (tx_bit == $past(enc_bit)));

    // R10: automatic selection follows the status flag edge for edge
    p_status_link_r10: assert property (@(posedge clk) disable iff (rst)
        (!auto_off && !force_quiet) |=> ((src_q == SRC_QUIET) == idle_flag));

    // R1: reset leaves both outputs low
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!tx_bit && !idle_flag));

endmodule

// File: tb/tb_idle_quiet_switch.sv
module tb_idle_quiet_switch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_bit = 1'b0;
    logic       below_thr = 1'b0;
    logic [3:0] dly_code = 4'd0;
    logic       auto_off = 1'b0;
    logic       force_quiet = 1'b0;
    logic       pwr_down = 1'b0;
    logic       tx_bit;
    logic       idle_flag;

    idle_quiet_switch dut (
        .clk(clk), .rst(rst), .enc_bit(enc_bit), .below_thr(below_thr),
        .dly_code(dly_code), .auto_off(auto_off), .force_quiet(force_quiet),
        .pwr_down(pwr_down), .tx_bit(tx_bit), .idle_flag(idle_flag)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit    q_tx[$];
    bit    q_idle[$];
    string q_tag[$];

    // Reference model state
    int m_run = 0;
    bit m_idle = 0, m_sel = 0, m_pat = 0, m_tx = 0;
    string cur_tag = "R1";

    task automatic step(input bit r, input bit e, input bit b, input int code,
                        input bit ao, input bit fq, input bit pd);
        bit idle_n, sel_n;
        @(negedge clk);
        rst = r; enc_bit = e; below_thr = b; dly_code = code[3:0];
        auto_off = ao; force_quiet = fq; pwr_down = pd;
        if (r) begin
            m_run = 0; m_idle = 0; m_sel = 0; m_pat = 0; m_tx = 0;
        end else begin
            idle_n = 0;
            if (pd || !b) m_run = 0;
            else begin
                idle_n = (m_run >= code * 32);
                if (m_run < 480) m_run++;
            end
            sel_n = fq || (idle_n && !ao);
            if (sel_n) begin
                m_pat = m_sel ? ~m_pat : 1'b1;
                m_tx  = m_pat;
            end else m_tx = e;
            m_sel  = sel_n;
            m_idle = idle_n;
        end
        q_tx.push_back(m_tx);
        q_idle.push_back(m_idle);
        q_tag.push_back(cur_tag);
    endtask

    task automatic run(input int n, input bit b, input int code, input bit ao,
                       input bit fq, input bit pd);
        for (int i = 0; i < n; i++)
            step(1'b0, 1'($urandom_range(0, 1)), b, code, ao, fq, pd);
    endtask

    // Monitor: compares outputs shortly after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tx.size() > 0) begin
                bit et, ei;
                string tg;
                et = q_tx.pop_front();
                ei = q_idle.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if (tx_bit !== et || idle_flag !== ei) begin
                    errors++;
                    $display("FAIL %s tx_bit=%0b idle_flag=%0b expected tx_bit=%0b idle_flag=%0b",
                             tg, tx_bit, idle_flag, et, ei);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before scenarios completed");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R9";  run(12, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R3";  run(1, 1'b1, 0, 1'b0, 1'b0, 1'b0);       // R3 code 0 rises at once
        cur_tag = "R2";  run(8, 1'b1, 0, 1'b0, 1'b0, 1'b0);       // R2 alternation, R10 link
        cur_tag = "R4";  run(4, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R5";  run(20, 1'b1, 1, 1'b0, 1'b0, 1'b0);
        run(1, 1'b0, 1, 1'b0, 1'b0, 1'b0);
        run(40, 1'b1, 1, 1'b0, 1'b0, 1'b0);                        // rises after 33rd edge
        cur_tag = "R10"; run(3, 1'b0, 1, 1'b0, 1'b0, 1'b0);
        cur_tag = "R3";  run(490, 1'b1, 15, 1'b0, 1'b0, 1'b0);    // largest delay
        run(2, 1'b0, 15, 1'b0, 1'b0, 1'b0);
        cur_tag = "R6";  run(12, 1'b1, 0, 1'b1, 1'b0, 1'b0);
        run(3, 1'b0, 0, 1'b1, 1'b0, 1'b0);
        cur_tag = "R7";  run(9, 1'b0, 7, 1'b1, 1'b1, 1'b0);
        run(5, 1'b1, 0, 1'b0, 1'b1, 1'b1);
        run(3, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R8";  run(10, 1'b1, 0, 1'b0, 1'b0, 1'b1);
        run(36, 1'b1, 1, 1'b0, 1'b0, 1'b0);                        // full run again after power-down
        cur_tag = "R1";  step(1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b1, 1'b0);
        cur_tag = "R9";  run(4, 1'b0, 1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule